// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. The counter advances once per cycle in which the `tick_en` strobe is high. It is compared against a 64-bit period that software programs. Software reaches the block through a plain 32-bit register port with read and write strobes and a byte offset. That port is always ready and has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high and holds until the next read.

Arming uses an ordered pair of 16-bit keys written to the key field of the watchdog control word. The first key, together with the enable bit, moves the block from off to a pre-armed state. The second key makes it armed. From then on the configuration is frozen. Servicing repeats the same pair, which clears the count. A key out of order while armed is treated as tampering and requests a reset at once. If the count reaches the period, the sticky expiry flag is set and a reset is requested. Either way the block then parks in a terminal state until system reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `rst_req` is 0. The identity word at offset 0x00 reads the `ID_VALUE` parameter. Count, period and watchdog control read 0.
- R2: While the block is off, these registers read back what was written: the count halves (0x10 low, 0x14 high), the period halves (0x18 low, 0x1C high), timer control 0x20 (only bits [7:6] kept), global control 0x24 (only bits [3:0] kept) and emulation control 0x04 (only bits [1:0] kept).
- R3: The count increases by one on each cycle in which all of these hold: `tick_en` is high, timer control bits [7:6] equal 2, global control bits 0 and 1 are both 1, and global control bits [3:2] equal 2. The carry passes from the low half into the high half.
- R4: Two writes arm the block. First, a write to watchdog control (0x28) with bits [31:16] = 0xA5C6 and bit 14 = 1 enters pre-armed. Then a write with key 0xDA7E enters armed. Watchdog control bit 14 then reads 1.
- R5: Once pre-armed or armed, writes to offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 change nothing, and bit 14 of watchdog control cannot be cleared.
- R6: While armed, writing key 0xA5C6 and then 0xDA7E clears the whole count. Repeated 0xA5C6 writes keep the service pending.
- R7: While armed or service-pending, any key other than the expected next one raises `rst_req` in the cycle after the write. Watchdog control bit 15 stays 0.
- R8: While armed or service-pending, a count greater than or equal to the period sets watchdog control bit 15 and raises `rst_req` in the next cycle. Expiry takes priority over a key written in the same cycle.
- R9: `rst_req` stays high for exactly `RST_CYC` cycles. After that the block stays timed out: the count is frozen, keys have no effect, and bit 15 stays set until system reset.
- R10: A period of zero programmed before arming causes an expiry in the first cycle after the block becomes armed, whatever `tick_en` is.
- R11: While off or pre-armed, a wrong key never raises `rst_req`, and the count cannot expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench builds the block with `RST_CYC` = 3 and a distinctive `ID_VALUE`. This keeps every reset pulse short enough to measure edge by edge, and it makes the identity read unambiguous. Periods of 0, 20 and 1000 are programmed at run time. These bring the zero-period case, a cycle-exact expiry and a long service window within reach. A count preset just below a 32-bit boundary exercises the carry between the halves.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_PRE  = 3'd1,
    ST_RUN  = 3'd2,
    ST_SVC  = 3'd3,
    ST_TRIP = 3'd4
  } wdk_state_e;

  // word indices (byte offset >> 2)
  localparam logic [3:0] IX_ID     = 4'h0;
  localparam logic [3:0] IX_EMU    = 4'h1;
  localparam logic [3:0] IX_CNT_LO = 4'h4;
  localparam logic [3:0] IX_PRD_LO = 4'h6;
  localparam logic [3:0] IX_TCTL   = 4'h8;
  localparam logic [3:0] IX_GCTL   = 4'h9;
  localparam logic [3:0] IX_WCTL   = 4'hA;

  localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [15:0] KEY_SECOND = 16'hDA7E;

  localparam int WCTL_EN_BIT   = 14;
  localparam int WCTL_FLAG_BIT = 15;
  localparam int WCTL_KEY_LSB  = 16;
  localparam int TCTL_MODE_LSB = 6;

  localparam logic [1:0] MODE_CONT = 2'd2;
  localparam logic [1:0] GSEL_WDOG = 2'd2;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 6,
  parameter int              NH       = 2,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 locked,
  input  logic                 flag,
  input  logic [NH*DATA_W-1:0] count,
  output logic [NH*DATA_W-1:0] period,
  output logic [NH-1:0]        cnt_ld,
  output logic                 run_cfg,
  output logic                 key_wr,
  output logic [15:0]          key_val,
  output logic                 key_en
);
  localparam int IX_W = ADDR_W - 2;

  logic [IX_W-1:0] ix;
  logic            wr_ok;
  logic [1:0]      emu_q;
  logic [1:0]      mode_q;
  logic [3:0]      gctl_q;
  logic            en_q;
  logic [DATA_W-1:0] rd_mux;

  assign ix    = addr[ADDR_W-1:2];
  assign wr_ok = wr_en && !locked;

  for (genvar h = 0; h < NH; h++) begin : g_half
    logic [DATA_W-1:0] prd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prd_q <= '0;
      else if (wr_ok && ix == IX_W'(IX_PRD_LO + h))
        prd_q <= wdata;
    end
    assign period[h*DATA_W +: DATA_W] = prd_q;
    assign cnt_ld[h] = wr_ok && (ix == IX_W'(IX_CNT_LO + h));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emu_q  <= '0;
      mode_q <= '0;
      gctl_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_ok) begin
      if (ix == IX_W'(IX_EMU))  emu_q  <= wdata[1:0];
      if (ix == IX_W'(IX_TCTL)) mode_q <= wdata[TCTL_MODE_LSB +: 2];
      if (ix == IX_W'(IX_GCTL)) gctl_q <= wdata[3:0];
      if (ix == IX_W'(IX_WCTL)) en_q   <= wdata[WCTL_EN_BIT];
    end
  end

  assign run_cfg = (mode_q == MODE_CONT) && gctl_q[0] && gctl_q[1] &&
                   (gctl_q[3:2] == GSEL_WDOG);
  assign key_wr  = wr_en && (ix == IX_W'(IX_WCTL));
  assign key_val = wdata[WCTL_KEY_LSB +: 16];
  assign key_en  = wdata[WCTL_EN_BIT];

  always_comb begin
    rd_mux = '0;
    if (ix == IX_W'(IX_ID))   rd_mux = ID_VALUE;
    if (ix == IX_W'(IX_EMU))  rd_mux[1:0] = emu_q;
    if (ix == IX_W'(IX_TCTL)) rd_mux[TCTL_MODE_LSB +: 2] = mode_q;
    if (ix == IX_W'(IX_GCTL)) rd_mux[3:0] = gctl_q;
    if (ix == IX_W'(IX_WCTL)) begin
      rd_mux[WCTL_FLAG_BIT] = flag;
      rd_mux[WCTL_EN_BIT]   = en_q;
    end
    for (int h = 0; h < NH; h++) begin
      if (ix == IX_W'(IX_CNT_LO + h)) rd_mux = count[h*DATA_W +: DATA_W];
      if (ix == IX_W'(IX_PRD_LO + h)) rd_mux = period[h*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int DATA_W = 32,
  parameter int NH     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clr,
  input  logic [NH-1:0]        ld,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NH*DATA_W-1:0] period,
  output logic [NH*DATA_W-1:0] count,
  output logic                 hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (|ld) begin
      for (int h = 0; h < NH; h++)
        if (ld[h]) count[h*DATA_W +: DATA_W] <= wdata;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end

  assign hit = (count >= period);
endmodule

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
  import wdk_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [15:0] key_val,
  input  logic       key_en,
  input  logic       hit,
  output wdk_state_e state,
  output logic       svc_clr,
  output logic       flag,
  output logic       rst_req
);
  localparam int PW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  wdk_state_e nxt;
  logic       trip, expire;
  logic [PW-1:0] left_q;

  always_comb begin
    nxt     = state;
    trip    = 1'b0;
    expire  = 1'b0;
    svc_clr = 1'b0;
    unique case (state)
      ST_OFF: if (key_wr && key_en && key_val == KEY_FIRST) nxt = ST_PRE;
      ST_PRE: if (key_wr && key_val == KEY_SECOND) nxt = ST_RUN;
      ST_RUN: begin
        if (hit)                          expire = 1'b1;
        else if (key_wr) begin
          if (key_val == KEY_FIRST)       nxt = ST_SVC;
          else                            trip = 1'b1;
        end
      end
      ST_SVC: begin
        if (hit)                          expire = 1'b1;
        else if (key_wr) begin
          if (key_val == KEY_SECOND) begin
            nxt     = ST_RUN;
            svc_clr = 1'b1;
          end else if (key_val != KEY_FIRST) begin
            trip = 1'b1;
          end
        end
      end
      default: nxt = ST_TRIP;
    endcase
    if (trip || expire) nxt = ST_TRIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      flag    <= 1'b0;
      rst_req <= 1'b0;
      left_q  <= '0;
    end else begin
      state <= nxt;
      if (expire) flag <= 1'b1;
      if (trip || expire) begin
        rst_req <= 1'b1;
        left_q  <= PW'(RST_CYC - 1);
      end else if (rst_req) begin
        if (left_q == '0) rst_req <= 1'b0;
        else              left_q  <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 6,
  parameter int                RST_CYC  = 16,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5744_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int NH    = 2;
  localparam int CNT_W = NH * DATA_W;

  wdk_state_e       fsm_state;
  logic [CNT_W-1:0] count_w, period_w;
  logic [NH-1:0]    cnt_ld;
  logic             run_cfg, key_wr, key_en, hit, svc_clr, flag;
  logic [15:0]      key_val;
  logic             cnt_run;

  assign cnt_run = run_cfg && tick_en && (fsm_state != ST_TRIP);

  wdk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NH(NH), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .locked(fsm_state != ST_OFF),
    .flag(flag), .count(count_w), .period(period_w), .cnt_ld(cnt_ld),
    .run_cfg(run_cfg), .key_wr(key_wr), .key_val(key_val), .key_en(key_en)
  );

  wdk_counter #(.DATA_W(DATA_W), .NH(NH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cnt_run), .clr(svc_clr), .ld(cnt_ld),
    .wdata(bus_wdata), .period(period_w), .count(count_w), .hit(hit)
  );

  wdk_keyfsm #(.RST_CYC(RST_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val),
    .key_en(key_en), .hit(hit), .state(fsm_state), .svc_clr(svc_clr),
    .flag(flag), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
  import wdk_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int RST_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input wdk_state_e       state,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic             flag,
  input logic             rst_req
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (rst_req) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  p_lock_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != ST_OFF) |-> $stable(period));

  p_svc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_SVC && state == ST_RUN) |-> (count == '0));

  p_trip_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIP && $past(state) != ST_TRIP) |-> rst_req);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag) |-> flag);

  p_pulse_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (32'(run_len) < RST_CYC));

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (32'(run_len) == RST_CYC));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIP && $past(state) == ST_TRIP) |-> $stable(count));

  p_quiet_unarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF || state == ST_PRE) |-> !rst_req);
endmodule

bind keyed_wdog wdk_checker #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(fsm_state), .count(count_w),
  .period(period_w), .flag(flag), .rst_req(rst_req)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int          RST_CYC = 3;
  localparam logic [31:0] IDV     = 32'h1234_ABCD;
  localparam logic [5:0] A_ID = 6'h00, A_EMU = 6'h04, A_CLO = 6'h10, A_CHI = 6'h14,
                         A_PLO = 6'h18, A_PHI = 6'h1C, A_TC = 6'h20, A_GC = 6'h24,
                         A_WC = 6'h28;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rst_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  keyed_wdog #(.RST_CYC(RST_CYC), .ID_VALUE(IDV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(logic [31:0] plo, logic [31:0] phi);
    wr(A_TC, 32'h80); wr(A_GC, 32'hB);
    wr(A_PLO, plo); wr(A_PHI, phi);
    wr(A_CLO, 0); wr(A_CHI, 0);
  endtask

  task automatic arm();
    wr(A_WC, 32'hA5C6_4000);
    wr(A_WC, 32'hDA7E_4000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 rst_req", 32'(rst_req), 0);
    rd(A_ID, d);  chk("R1 id", d, IDV);
    rd(A_CLO, d); chk("R1 count", d, 0);
    rd(A_PHI, d); chk("R1 period", d, 0);
    rd(A_WC, d);  chk("R1 wctl", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_PLO, 32'hDEAD_BEEF); rd(A_PLO, d); chk("R2 period lo", d, 32'hDEAD_BEEF);
    wr(A_PHI, 32'h0102_0304); rd(A_PHI, d); chk("R2 period hi", d, 32'h0102_0304);
    wr(A_CHI, 32'h0000_00AA); rd(A_CHI, d); chk("R2 count hi", d, 32'hAA);
    wr(A_TC, 32'hFFFF_FFFF);  rd(A_TC, d);  chk("R2 tctl mask", d, 32'hC0);
    wr(A_GC, 32'hFFFF_FFFF);  rd(A_GC, d);  chk("R2 gctl mask", d, 32'hF);
    wr(A_EMU, 32'hFFFF_FFFF); rd(A_EMU, d); chk("R2 emu mask", d, 32'h3);
  endtask

  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr(A_TC, 32'h40); wr(A_GC, 32'hB); wr(A_CLO, 32'd5);
    @(negedge clk); tick_en = 1'b1; repeat (4) @(negedge clk); tick_en = 1'b0;
    rd(A_CLO, d); chk("R3 one-shot mode holds", d, 5);
    wr(A_TC, 32'h80); wr(A_GC, 32'h9);
    @(negedge clk); tick_en = 1'b1; repeat (4) @(negedge clk); tick_en = 1'b0;
    rd(A_CLO, d); chk("R3 half in reset holds", d, 5);
    wr(A_GC, 32'hB);
    repeat (3) @(negedge clk);
    rd(A_CLO, d); chk("R3 tick low holds", d, 5);
    wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 0);
    @(negedge clk); tick_en = 1'b1; repeat (2) @(negedge clk); tick_en = 1'b0;
    rd(A_CLO, d); chk("R3 carry lo", d, 0);
    rd(A_CHI, d); chk("R3 carry hi", d, 1);
  endtask

  task automatic t_arm_lock();
    logic [31:0] d;
    do_reset();
    setup(32'd1000, 0);
    wr(A_WC, 32'h1234_4000);
    chk("R11 bad key off", 32'(rst_req), 0);
    wr(A_WC, 32'hA5C6_0000);
    wr(A_PLO, 32'd1000); rd(A_PLO, d); chk("R4 no arm without enable", d, 1000);
    wr(A_WC, 32'hA5C6_4000);
    wr(A_WC, 32'h1111_4000);
    @(negedge clk); chk("R11 bad key pre-armed", 32'(rst_req), 0);
    wr(A_WC, 32'hDA7E_4000);
    rd(A_WC, d); chk("R4 enable reads 1", d, 32'h4000);
    wr(A_PLO, 32'd5);  rd(A_PLO, d); chk("R5 period locked", d, 1000);
    wr(A_CLO, 32'd77); rd(A_CLO, d); chk("R5 count locked", d, 0);
    wr(A_TC, 32'h0);   wr(A_GC, 32'h0);
    rd(A_TC, d); chk("R5 tctl locked", d, 32'h80);
    rd(A_GC, d); chk("R5 gctl locked", d, 32'hB);
    wr(A_WC, 32'hA5C6_0000); wr(A_WC, 32'hDA7E_0000);
    rd(A_WC, d); chk("R5 enable sticky", d, 32'h4000);
    chk("R5 service ok", 32'(rst_req), 0);
  endtask

  task automatic t_service();
    logic [31:0] d;
    do_reset();
    setup(32'd1000, 0);
    arm();
    @(negedge clk); tick_en = 1'b1; repeat (10) @(negedge clk); tick_en = 1'b0;
    rd(A_CLO, d); chk("R6 counted", d, 10);
    wr(A_WC, 32'hA5C6_0000); wr(A_WC, 32'hA5C6_0000);
    chk("R6 double first key", 32'(rst_req), 0);
    wr(A_WC, 32'hDA7E_0000);
    rd(A_CLO, d); chk("R6 count cleared", d, 0);
    chk("R6 no reset", 32'(rst_req), 0);
  endtask

  task automatic t_badkey();
    logic [31:0] d;
    int len;
    do_reset();
    setup(32'd1000, 0);
    arm();
    wr(A_WC, 32'hDA7E_0000);
    chk("R7 reset on wrong key", 32'(rst_req), 1);
    len = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_req) len++; else break;
    end
    chk("R9 pulse length", len, RST_CYC);
    rd(A_WC, d); chk("R7 flag clear", d, 32'h4000);
    wr(A_WC, 32'h0000_0000);
    @(negedge clk); chk("R9 keys ignored", 32'(rst_req), 0);
    do_reset();
    setup(32'd1000, 0);
    arm();
    wr(A_WC, 32'hA5C6_0000);
    wr(A_WC, 32'hBEEF_0000);
    chk("R7 wrong key pending", 32'(rst_req), 1);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int n, len;
    do_reset();
    setup(32'd20, 0);
    arm();
    @(negedge clk); tick_en = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      if (rst_req) break;
    end
    chk("R8 expiry cycle", n, 21);
    len = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_req) len++; else break;
    end
    chk("R9 pulse length", len, RST_CYC);
    rd(A_WC, d);  chk("R8 flag set", d, 32'hC000);
    rd(A_CLO, d); chk("R9 count frozen", d, 21);
    wr(A_WC, 32'hA5C6_0000); wr(A_WC, 32'hDA7E_0000);
    rd(A_CLO, d); chk("R9 key no clear", d, 21);
    chk("R9 no new pulse", 32'(rst_req), 0);
    rd(A_WC, d);  chk("R9 flag sticky", d, 32'hC000);
    tick_en = 1'b0;
    do_reset();
    rd(A_WC, d);  chk("R9 flag cleared by reset", d, 0);
  endtask

  task automatic t_zero();
    do_reset();
    setup(32'd0, 0);
    wr(A_WC, 32'hA5C6_4000);
    chk("R11 no expiry pre-armed", 32'(rst_req), 0);
    wr(A_WC, 32'hDA7E_4000);
    chk("R10 not yet", 32'(rst_req), 0);
    @(negedge clk);
    chk("R10 zero period expiry", 32'(rst_req), 1);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_count();
    t_arm_lock();
    t_service();
    t_badkey();
    t_timeout();
    t_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule